// File: doc/BRIEF.md
# Script I/O Instruction Execution Unit

This unit carries out the I/O instructions of a script-driven bus controller. Three are real work: set, clear and wait-for-reselection. A fourth code is a no-op. The instruction fetcher hands over a decoded instruction in one cycle, marked by `start`. That instruction carries an opcode, five flag bits, a 32-bit jump field and the script pointer of the instruction. The unit then reports the address of the next instruction to fetch, with a one-cycle `done` and `fetch_req` pulse.

Set and clear act on three pieces of state at once: the output-control latch (ACK and ATN), the target-mode bit and the ALU carry. A wait instruction holds the unit busy until one of three events arrives. A host signal-process request aborts the wait. A select event sends the script to the alternate address and enters target mode. A reselect event continues with the instruction that follows. The alternate address is either the absolute jump field or a signed 24-bit displacement from the advanced script pointer.

Top module: `sio_exec`

## Requirements
- R1: In the cycle after synchronous reset, `out_latch`, `target_mode`, `alu_carry`, `busy`, `done`, `fetch_req` and `tgt_entry` are all 0.
- R2: The opcode encoding is 00 wait-reselect, 01 set, 10 clear and 11 no-op. In a set, each asserted flag sets its bit: `flag_ack` sets `out_latch[1]`, `flag_atn` sets `out_latch[0]`, `flag_tgt` sets `target_mode` and `flag_carry` sets `alu_carry`.
- R3: In a clear, each asserted flag clears the same bit. A bit whose flag is not asserted keeps its value.
- R4: For set, clear and no-op, `done` and `fetch_req` pulse one cycle after `start`, and `next_ptr` is `script_ptr + 8`.
- R5: A wait raises `busy` one cycle after `start`. `busy` stays high, with no `done`, until an event resolves the wait. `busy` falls in the same cycle that `done` pulses.
- R6: If only a reselect event resolves a wait, `next_ptr` is `script_ptr + 8` of the waiting instruction.
- R7: If a select event resolves a wait, `next_ptr` is the alternate address, `tgt_entry` pulses together with `done`, and `target_mode` becomes 1.
- R8: A signal-process request resolves a wait to the alternate address without entering target mode. It takes priority over select and reselect in the same cycle.
- R9: When select and reselect arrive in the same cycle, select wins.
- R10: The alternate address is `jump_field` when `flag_rel` is 0. When `flag_rel` is 1, it is `script_ptr + 8` plus the sign-extended `jump_field[23:0]`, and bits 31:24 are ignored.
- R11: A `start` while a wait is pending is ignored. Events that arrive while no wait is pending have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Decoded instruction valid for one cycle |
| opcode | input | 2 | Instruction code |
| flag_ack | input | 1 | ACK flag |
| flag_atn | input | 1 | ATN flag |
| flag_tgt | input | 1 | Target-mode flag |
| flag_carry | input | 1 | Carry flag |
| flag_rel | input | 1 | Relative addressing for the alternate address |
| jump_field | input | 32 | Jump / displacement field |
| script_ptr | input | 32 | Address of the current instruction |
| ev_select | input | 1 | Select event strobe |
| ev_reselect | input | 1 | Reselect event strobe |
| ev_sigp | input | 1 | Host signal-process request |
| next_ptr | output | 32 | Next fetch address, valid with `done` |
| fetch_req | output | 1 | Fetch request pulse |
| done | output | 1 | Instruction complete pulse |
| busy | output | 1 | Wait pending |
| out_latch | output | 2 | Output-control latch, bit 1 ACK, bit 0 ATN |
| target_mode | output | 1 | Target-mode bit |
| alu_carry | output | 1 | ALU carry flag |
| tgt_entry | output | 1 | Target-mode entry pulse |

## Verification
Some properties are checked on every cycle. State bits may change only in a cycle that shows `done`. `busy` and `done` are never high together, and `busy` falls only with `done`. A target-entry pulse always comes with `done` and a set target bit, and the reset state holds.

Other behaviour can only be shown by the bench scenarios. These cover the address each event picks, the priority among events in the same cycle, and signed relative arithmetic in both directions. They also show that the upper jump bits are ignored in relative mode, that starts and events arriving in the wrong state are ignored, and that set or clear leaves bits with unasserted flags alone.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    OPC_WAIT_RESEL = 2'b00,
    OPC_SET        = 2'b01,
    OPC_CLEAR      = 2'b10,
    OPC_NOP        = 2'b11
  } sio_op_e;

  typedef struct packed {
    logic ack;
    logic atn;
    logic tgt;
    logic carry;
  } sio_flags_t;
endpackage

// File: rtl/sio_target_calc.sv
module sio_target_calc #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 24,
  parameter int STEP   = 8
) (
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic [ADDR_W-1:0] jump,
  input  logic              rel,
  output logic [ADDR_W-1:0] adv_ptr,
  output logic [ADDR_W-1:0] alt_ptr
);
  localparam int EXT_W = ADDR_W - DISP_W;
  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{jump[DISP_W-1]}}, jump[DISP_W-1:0]};
    end else begin : g_noext
      assign disp_ext = jump;
    end
  endgenerate

  always_comb begin
    adv_ptr = cur_ptr + ADDR_W'(STEP);
    alt_ptr = rel ? (adv_ptr + disp_ext) : jump;
  end
endmodule

// File: rtl/sio_wait_arbiter.sv
module sio_wait_arbiter (
  input  logic pending,
  input  logic ev_select,
  input  logic ev_reselect,
  input  logic ev_sigp,
  output logic resolve,
  output logic use_alt,
  output logic enter_tgt
);
  always_comb begin
    resolve   = 1'b0;
    use_alt   = 1'b0;
    enter_tgt = 1'b0;
    if (pending) begin
      if (ev_sigp) begin
        resolve = 1'b1;
        use_alt = 1'b1;
      end else if (ev_select) begin
        resolve   = 1'b1;
        use_alt   = 1'b1;
        enter_tgt = 1'b1;
      end else if (ev_reselect) begin
        resolve = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_state_bits.sv
module sio_state_bits
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       do_set,
  input  logic       do_clr,
  input  sio_flags_t flags,
  input  logic       tgt_hit,
  output logic [1:0] out_latch,
  output logic       target_mode,
  output logic       alu_carry
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_latch   <= 2'b00;
      target_mode <= 1'b0;
      alu_carry   <= 1'b0;
    end else begin
      if (do_set) begin
        if (flags.ack)   out_latch[1] <= 1'b1;
        if (flags.atn)   out_latch[0] <= 1'b1;
        if (flags.tgt)   target_mode  <= 1'b1;
        if (flags.carry) alu_carry    <= 1'b1;
      end else if (do_clr) begin
        if (flags.ack)   out_latch[1] <= 1'b0;
        if (flags.atn)   out_latch[0] <= 1'b0;
        if (flags.tgt)   target_mode  <= 1'b0;
        if (flags.carry) alu_carry    <= 1'b0;
      end
      if (tgt_hit) target_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/sio_exec.sv
module sio_exec
  import sio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 24,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic              flag_ack,
  input  logic              flag_atn,
  input  logic              flag_tgt,
  input  logic              flag_carry,
  input  logic              flag_rel,
  input  logic [ADDR_W-1:0] jump_field,
  input  logic [ADDR_W-1:0] script_ptr,
  input  logic              ev_select,
  input  logic              ev_reselect,
  input  logic              ev_sigp,
  output logic [ADDR_W-1:0] next_ptr,
  output logic              fetch_req,
  output logic              done,
  output logic              busy,
  output logic [1:0]        out_latch,
  output logic              target_mode,
  output logic              alu_carry,
  output logic              tgt_entry
);
  sio_op_e           op;
  sio_flags_t        flags;
  logic              pending;
  logic              accept;
  logic [ADDR_W-1:0] adv_c, alt_c, adv_q, alt_q;
  logic              resolve, use_alt, enter_tgt;

  assign op     = sio_op_e'(opcode);
  assign flags  = '{ack: flag_ack, atn: flag_atn, tgt: flag_tgt, carry: flag_carry};
  assign accept = start && !pending;
  assign busy   = pending;

  sio_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .STEP(STEP)) u_calc (
    .cur_ptr (script_ptr),
    .jump    (jump_field),
    .rel     (flag_rel),
    .adv_ptr (adv_c),
    .alt_ptr (alt_c)
  );

  sio_wait_arbiter u_arb (
    .pending     (pending),
    .ev_select   (ev_select),
    .ev_reselect (ev_reselect),
    .ev_sigp     (ev_sigp),
    .resolve     (resolve),
    .use_alt     (use_alt),
    .enter_tgt   (enter_tgt)
  );

  sio_state_bits u_bits (
    .clk         (clk),
    .rst         (rst),
    .do_set      (accept && op == OPC_SET),
    .do_clr      (accept && op == OPC_CLEAR),
    .flags       (flags),
    .tgt_hit     (resolve && enter_tgt),
    .out_latch   (out_latch),
    .target_mode (target_mode),
    .alu_carry   (alu_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      done      <= 1'b0;
      fetch_req <= 1'b0;
      tgt_entry <= 1'b0;
      next_ptr  <= '0;
      adv_q     <= '0;
      alt_q     <= '0;
    end else begin
      done      <= 1'b0;
      fetch_req <= 1'b0;
      tgt_entry <= 1'b0;
      if (accept) begin
        if (op == OPC_WAIT_RESEL) begin
          pending <= 1'b1;
          adv_q   <= adv_c;
          alt_q   <= alt_c;
        end else begin
          done      <= 1'b1;
          fetch_req <= 1'b1;
          next_ptr  <= adv_c;
        end
      end else if (resolve) begin
        pending   <= 1'b0;
        done      <= 1'b1;
        fetch_req <= 1'b1;
        next_ptr  <= use_alt ? alt_q : adv_q;
        tgt_entry <= enter_tgt;
      end
    end
  end
endmodule

// File: rtl/sio_exec_checker.sv
module sio_exec_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       done,
  input logic       busy,
  input logic [1:0] out_latch,
  input logic       target_mode,
  input logic       alu_carry,
  input logic       tgt_entry
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_latch == 2'b00 && !target_mode && !alu_carry && !busy && !done && !tgt_entry));

  assert_latch_only_on_done_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_latch) |-> done);

  assert_carry_only_on_done_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(alu_carry) |-> done);

  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_busy_falls_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_busy_rises_from_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_entry_with_target_R7: assert property (@(posedge clk) disable iff (rst)
    tgt_entry |-> (done && target_mode));
endmodule

bind sio_exec sio_exec_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .done        (done),
  .busy        (busy),
  .out_latch   (out_latch),
  .target_mode (target_mode),
  .alu_carry   (alu_carry),
  .tgt_entry   (tgt_entry)
);

// File: tb/sio_exec_bench.sv
module sio_exec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  opcode;
  logic        flag_ack, flag_atn, flag_tgt, flag_carry, flag_rel;
  logic [31:0] jump_field, script_ptr;
  logic        ev_select, ev_reselect, ev_sigp;
  logic [31:0] next_ptr;
  logic        fetch_req, done, busy, target_mode, alu_carry, tgt_entry;
  logic [1:0]  out_latch;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_exec u_sio_exec (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .flag_ack(flag_ack), .flag_atn(flag_atn), .flag_tgt(flag_tgt),
    .flag_carry(flag_carry), .flag_rel(flag_rel),
    .jump_field(jump_field), .script_ptr(script_ptr),
    .ev_select(ev_select), .ev_reselect(ev_reselect), .ev_sigp(ev_sigp),
    .next_ptr(next_ptr), .fetch_req(fetch_req), .done(done), .busy(busy),
    .out_latch(out_latch), .target_mode(target_mode), .alu_carry(alu_carry),
    .tgt_entry(tgt_entry)
  );

  typedef struct {
    logic [31:0] nxt;
    logic [1:0]  latch;
    logic        tgt;
    logic        carry;
    logic        entry;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  logic [1:0] m_latch = 2'b00;
  logic       m_tgt = 1'b0, m_carry = 1'b0;
  logic [31:0] w_adv, w_alt;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (rst === 1'b0 && done === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", {32'b0, next_ptr}, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(next_ptr === e.nxt && fetch_req === 1'b1, e.tag, {31'b0, fetch_req, next_ptr}, {32'h1, e.nxt});
        chk(out_latch === e.latch && target_mode === e.tgt && alu_carry === e.carry &&
            tgt_entry === e.entry && busy === 1'b0, e.tag,
            {58'b0, busy, out_latch, target_mode, alu_carry, tgt_entry},
            {59'b0, e.latch, e.tgt, e.carry, e.entry});
      end
    end
  end

  task automatic idle_inputs();
    start = 0; opcode = 2'b11; flag_ack = 0; flag_atn = 0; flag_tgt = 0;
    flag_carry = 0; flag_rel = 0; jump_field = '0; script_ptr = '0;
    ev_select = 0; ev_reselect = 0; ev_sigp = 0;
  endtask

  // Set / clear / no-op: expected state computed from R2, R3, R4
  task automatic run_simple(input logic [1:0] op, input logic a, input logic t, input logic g,
                            input logic c, input logic [31:0] ptr, input string tag);
    exp_t e;
    @(negedge clk);
    if (op == 2'b01) begin
      if (a) m_latch[1] = 1; if (t) m_latch[0] = 1; if (g) m_tgt = 1; if (c) m_carry = 1;
    end else if (op == 2'b10) begin
      if (a) m_latch[1] = 0; if (t) m_latch[0] = 0; if (g) m_tgt = 0; if (c) m_carry = 0;
    end
    e.nxt = ptr + 32'd8; e.latch = m_latch; e.tgt = m_tgt; e.carry = m_carry; e.entry = 0; e.tag = tag;
    exp_q.push_back(e);
    start = 1; opcode = op; flag_ack = a; flag_atn = t; flag_tgt = g; flag_carry = c; script_ptr = ptr;
    @(negedge clk);
    start = 0; flag_ack = 0; flag_atn = 0; flag_tgt = 0; flag_carry = 0;
  endtask

  task automatic begin_wait(input logic [31:0] ptr, input logic [31:0] jf, input logic rel);
    @(negedge clk);
    w_adv = ptr + 32'd8;
    w_alt = rel ? (w_adv + {{8{jf[23]}}, jf[23:0]}) : jf;
    start = 1; opcode = 2'b00; flag_rel = rel; jump_field = jf; script_ptr = ptr;
    @(negedge clk);
    start = 0; flag_rel = 0;
    chk(busy === 1'b1 && done === 1'b0, "R5 busy after wait start", {62'b0, busy, done}, 64'h2);
  endtask

  task automatic end_wait(input logic s, input logic r, input logic p, input string tag);
    exp_t e;
    logic alt, ent;
    alt = p || s;
    ent = !p && s;
    if (ent) m_tgt = 1;
    e.nxt = alt ? w_alt : w_adv; e.latch = m_latch; e.tgt = m_tgt; e.carry = m_carry;
    e.entry = ent; e.tag = tag;
    exp_q.push_back(e);
    ev_select = s; ev_reselect = r; ev_sigp = p;
    @(negedge clk);
    ev_select = 0; ev_reselect = 0; ev_sigp = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_latch === 2'b00 && target_mode === 0 && alu_carry === 0, "R1 reset state bits",
        {61'b0, out_latch, target_mode}, 64'h0);
    chk(busy === 0 && done === 0 && fetch_req === 0 && tgt_entry === 0, "R1 reset control",
        {60'b0, busy, done, fetch_req, tgt_entry}, 64'h0);

    run_simple(2'b01, 1, 0, 0, 1, 32'h100, "R2 set ack+carry");
    run_simple(2'b01, 0, 1, 1, 0, 32'h108, "R2 set atn+target");
    run_simple(2'b10, 1, 0, 0, 0, 32'h110, "R3 clear ack keeps others");
    run_simple(2'b11, 1, 1, 1, 1, 32'h118, "R4 no-op changes nothing");
    run_simple(2'b10, 0, 0, 1, 0, 32'h120, "R3 clear target only");

    // R5, R6: wait several cycles then reselect
    begin_wait(32'h200, 32'h2000, 0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, "R5 still waiting", {62'b0, busy, done}, 64'h2);
    end_wait(0, 1, 0, "R6 reselect continues");

    // R7: select to absolute alternate, target entry
    begin_wait(32'h300, 32'h4000, 0);
    end_wait(1, 0, 0, "R7 select enters target");

    // R8: signal-process over select
    run_simple(2'b10, 0, 0, 1, 0, 32'h308, "R3 clear target again");
    begin_wait(32'h400, 32'h5000, 0);
    end_wait(1, 1, 1, "R8 sigp wins");

    // R9, R10: select beats reselect, negative relative displacement
    begin_wait(32'h1000, 32'h00FFFFF0, 1);
    end_wait(1, 1, 0, "R9 R10 select over reselect, negative rel");

    // R10: positive displacement, upper jump bits ignored, sigp abort
    begin_wait(32'h40, 32'hAB000100, 1);
    end_wait(0, 0, 1, "R10 R8 positive rel abort");

    // R11: start while busy ignored
    begin_wait(32'h600, 32'h7000, 0);
    @(negedge clk);
    start = 1; opcode = 2'b01; flag_carry = 1; flag_ack = 1; script_ptr = 32'h900;
    @(negedge clk);
    start = 0; flag_carry = 0; flag_ack = 0;
    chk(busy === 1'b1 && done === 1'b0, "R11 start while busy ignored", {62'b0, busy, done}, 64'h2);
    end_wait(0, 1, 0, "R11 wait resolves unchanged state");

    // R11: events with no wait pending
    @(negedge clk);
    ev_select = 1; ev_sigp = 1; ev_reselect = 1;
    @(negedge clk);
    ev_select = 0; ev_sigp = 0; ev_reselect = 0;
    @(negedge clk);
    chk(done === 0 && busy === 0 && target_mode === m_tgt, "R11 idle events ignored",
        {61'b0, done, busy, target_mode}, {63'b0, m_tgt});

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all results produced", 64'(exp_q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule